// File: doc/BRIEF.md
# Incremental ADC Conversion Sequencer

This block times the conversions of an incremental ADC. It runs on the modulator clock. Each conversion passes through three timed phases in a fixed order. The first is a reset phase that clears the loop filter. The second is a skip phase that lets the input settle. The third is an accumulation phase whose length equals the oversampling ratio. A separate strobe marks each phase, so the modulator and the decimator can follow along. A single-cycle pulse marks the last accumulation cycle, which is when the decimator's result is ready.

A conversion starts in one of two ways. The control logic can pulse a one-shot start input, or a rising edge can arrive on one of three general-purpose pins, picked by a source code. Four modes cover one-shot or free-running operation, each on a single channel or on a rotating channel index. A done flag reports the end of a one-shot run and stays set until it is cleared. A stop level ends a free-running run once the current conversion has finished. Clearing the enable input aborts any conversion at once.

The controller has four states: IDLE, RESET_PH, SKIP_PH and ACCUM_PH. Its transitions are:
- START: IDLE to RESET_PH, when enabled and a start request is present.
- RST_DONE: RESET_PH to SKIP_PH.
- SKIP_DONE: SKIP_PH to ACCUM_PH.
- NEXT_CONV: ACCUM_PH to RESET_PH, when another conversion follows.
- FINISH: ACCUM_PH to IDLE.
- ABORT: any busy state to IDLE, when the enable input is low.

Top module: `iadc_seq_top`

## Requirements
- R1: `mod_rst` stays high for exactly 50, 75, 100 or 150 cycles when `cfg_rst_sel` is 0, 1, 2 or 3.
- R2: `skip_ph` stays high for exactly 384, 576, 896, 1024, 2048 or 4096 cycles when `cfg_skip_sel` is 0 to 5. The reserved codes 6 and 7 behave as 4096.
- R3: `acc_ph` stays high for exactly 32, 64, 96 or 128 cycles when `cfg_osr_sel` is 0, 1, 2 or 3.
- R4: Within a conversion the phases run reset, then skip, then accumulation, with no gap between them. At most one phase strobe is high in any cycle. The busy time of a one-shot conversion equals the sum of the three phase lengths. `conv_end` is high only in the last accumulation cycle.
- R5: While `cfg_en` is 0, no start request has any effect. If `cfg_en` is low at a clock edge during a conversion, `busy` is 0 from that edge on.
- R6: A `oneshot_wr` pulse seen at an edge while idle and enabled makes `mod_rst` high from that edge. In one-shot modes, `done_sts` becomes 1 at the edge that ends the final accumulation cycle. Sequential modes never set it. A `done_clr` pulse clears it at the next edge, except when a set happens at the same edge; the set takes priority.
- R7: `cfg_trig_src` selects the start pin: 0 means no pin, 1 means `gpio_in[0]`, 2 means `gpio_in[1]` and 3 means `gpio_in[2]`. A pin that rises before edge k raises `mod_rst` after edge k+2. Unselected pins are ignored.
- R8: A start request from either source that arrives while `busy` is 1 is ignored. It neither restarts nor extends the run.
- R9: `cfg_mode` is 0 for one-shot single, 1 for one-shot multichannel, 2 for sequential single and 3 for sequential multichannel. One-shot multichannel converts channels 0, 1, 2 and 3 once each, back to back. Sequential multichannel steps the channel as 0, 1, 2, 3, 0 and so on. `chan_idx` is 0 when idle.
- R10: `stop_seq` is sampled in the last accumulation cycle of a sequential run. If it is 1, the block goes idle after that conversion; otherwise the next conversion starts in the following cycle.
- R11: In single-channel modes `chan_idx` stays 0 for every conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enable; low aborts and blocks conversions |
| cfg_mode | input | 2 | Mode code, latched at start |
| cfg_rst_sel | input | 2 | Reset-phase length code, latched at start |
| cfg_skip_sel | input | 3 | Skip-phase length code, latched at start |
| cfg_osr_sel | input | 2 | Oversampling ratio code, latched at start |
| cfg_trig_src | input | 2 | Start pin select |
| oneshot_wr | input | 1 | Start pulse from the control logic |
| stop_seq | input | 1 | Stop level for sequential modes |
| done_clr | input | 1 | Clear pulse for the done flag |
| gpio_in | input | 3 | Asynchronous start pins |
| mod_rst | output | 1 | Reset-phase strobe |
| skip_ph | output | 1 | Skip-phase strobe |
| acc_ph | output | 1 | Accumulation-phase strobe |
| conv_end | output | 1 | High in the last accumulation cycle |
| busy | output | 1 | A conversion is in progress |
| chan_idx | output | 2 | Channel of the current conversion |
| done_sts | output | 1 | One-shot done flag |

## Verification
Each result has a fixed latency:
- A register start or an enable drop shows on the strobes and `busy` one edge after it is sampled.
- A pin start shows three edges after the pin rises.
- `done_sts` changes one edge after the last accumulation cycle or the clear pulse.
- `chan_idx` changes together with the rising `mod_rst` of each new conversion.

The bench drives inputs on falling edges and samples on falling edges, which is half a period after the edge that updates the outputs. Phase lengths are measured by counting falling-edge samples while each strobe is high. The pin-start latency is checked cycle by cycle, so an extra or a missing register stage is caught.

// File: rtl/iadc_seq_pkg.sv
package iadc_seq_pkg;

    localparam int MAX_LEN = 4096;
    localparam int LEN_W   = $clog2(MAX_LEN) + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_SKIP  = 2'd2,
        ST_ACCUM = 2'd3
    } seq_state_t;

    // Phase lengths minus one, so the counter compares against the last index
    function automatic logic [LEN_W-1:0] rst_len_m1(input logic [1:0] code);
        unique case (code)
            2'd0:    return LEN_W'(49);
            2'd1:    return LEN_W'(74);
            2'd2:    return LEN_W'(99);
            default: return LEN_W'(149);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] skip_len_m1(input logic [2:0] code);
        unique case (code)
            3'd0:    return LEN_W'(383);
            3'd1:    return LEN_W'(575);
            3'd2:    return LEN_W'(895);
            3'd3:    return LEN_W'(1023);
            3'd4:    return LEN_W'(2047);
            default: return LEN_W'(4095); // 5 and the reserved codes
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] osr_len_m1(input logic [1:0] code);
        return LEN_W'((int'(code) + 1) * 32 - 1);
    endfunction

endpackage

// File: rtl/iadc_trig_sync.sv
module iadc_trig_sync #(
    parameter int N_PINS      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins,
    input  logic [SEL_W-1:0]  src_sel,
    output logic              start_edge
);

    logic [N_PINS-1:0] chain_q [SYNC_STAGES];
    logic              sel_pin;
    logic              prev_q;
    logic [SEL_W-1:0]  pin_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= pins;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign pin_idx = src_sel - SEL_W'(1);

    always_comb begin
        if (src_sel == '0) sel_pin = 1'b0;
        else               sel_pin = chain_q[SYNC_STAGES-1][pin_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_pin;
    end

    assign start_edge = sel_pin & ~prev_q;

endmodule

// File: rtl/iadc_phase_len.sv
module iadc_phase_len
    import iadc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       rst_code,
    input  logic [2:0]       skip_code,
    input  logic [1:0]       osr_code,
    output logic [LEN_W-1:0] rst_m1,
    output logic [LEN_W-1:0] skip_m1,
    output logic [LEN_W-1:0] acc_m1
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_m1  <= rst_len_m1(2'd1);
            skip_m1 <= skip_len_m1(3'd1);
            acc_m1  <= osr_len_m1(2'd3);
        end else if (load) begin
            rst_m1  <= rst_len_m1(rst_code);
            skip_m1 <= skip_len_m1(skip_code);
            acc_m1  <= osr_len_m1(osr_code);
        end
    end

endmodule

// File: rtl/iadc_seq_fsm.sv
module iadc_seq_fsm
    import iadc_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic             start_req,
    input  logic             stop_seq,
    input  logic             done_clr,
    input  logic [LEN_W-1:0] rst_m1,
    input  logic [LEN_W-1:0] skip_m1,
    input  logic [LEN_W-1:0] acc_m1,
    output logic             latch_cfg,
    output logic             mod_rst,
    output logic             skip_ph,
    output logic             acc_ph,
    output logic             conv_end,
    output logic             busy,
    output logic [CH_W-1:0]  chan_idx,
    output logic             done_sts
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    seq_state_t       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] cur_len;
    logic [1:0]       mode_q;
    logic [CH_W-1:0]  chan_q;
    logic             last_cyc;
    logic             more;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESET: cur_len = rst_m1;
            ST_SKIP:  cur_len = skip_m1;
            ST_ACCUM: cur_len = acc_m1;
            default:  cur_len = '0;
        endcase
    end

    assign last_cyc  = (cnt_q == cur_len);
    assign more      = mode_q[1] ? ~stop_seq : (mode_q[0] && (chan_q != LAST_CH));
    assign latch_cfg = (state_q == ST_IDLE) && en && start_req;

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + LEN_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (latch_cfg) state_d = ST_RESET;
            end
            ST_RESET: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (last_cyc) begin
                    state_d = ST_SKIP;
                    cnt_d   = '0;
                end
            end
            ST_SKIP: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (last_cyc) begin
                    state_d = ST_ACCUM;
                    cnt_d   = '0;
                end
            end
            ST_ACCUM: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (last_cyc) begin
                    state_d = more ? ST_RESET : ST_IDLE;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        mod_rst  = 1'b0;
        skip_ph  = 1'b0;
        acc_ph   = 1'b0;
        busy     = 1'b1;
        conv_end = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy    = 1'b0;
            ST_RESET: mod_rst = 1'b1;
            ST_SKIP:  skip_ph = 1'b1;
            ST_ACCUM: begin
                acc_ph   = 1'b1;
                conv_end = last_cyc && en;
            end
        endcase
    end

    // Mode snapshot, channel index and done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 2'd0;
            chan_q   <= '0;
            done_sts <= 1'b0;
        end else begin
            if (latch_cfg) mode_q <= mode;

            if (state_d == ST_IDLE) begin
                chan_q <= '0;
            end else if (conv_end && more && mode_q[0]) begin
                chan_q <= (chan_q == LAST_CH) ? '0 : chan_q + CH_W'(1);
            end

            if (conv_end && !more && !mode_q[1]) done_sts <= 1'b1;
            else if (done_clr)                   done_sts <= 1'b0;
        end
    end

    assign chan_idx = chan_q;

endmodule

// File: rtl/iadc_seq_top.sv
module iadc_seq_top
    import iadc_seq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int N_PINS      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_rst_sel,
    input  logic [2:0]        cfg_skip_sel,
    input  logic [1:0]        cfg_osr_sel,
    input  logic [1:0]        cfg_trig_src,
    input  logic              oneshot_wr,
    input  logic              stop_seq,
    input  logic              done_clr,
    input  logic [N_PINS-1:0] gpio_in,
    output logic              mod_rst,
    output logic              skip_ph,
    output logic              acc_ph,
    output logic              conv_end,
    output logic              busy,
    output logic [CH_W-1:0]   chan_idx,
    output logic              done_sts
);

    logic             trig_edge;
    logic             latch_cfg;
    logic [LEN_W-1:0] rst_m1, skip_m1, acc_m1;

    iadc_trig_sync #(
        .N_PINS      (N_PINS),
        .SYNC_STAGES (SYNC_STAGES),
        .SEL_W       (2)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins       (gpio_in),
        .src_sel    (cfg_trig_src),
        .start_edge (trig_edge)
    );

    iadc_phase_len u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (latch_cfg),
        .rst_code  (cfg_rst_sel),
        .skip_code (cfg_skip_sel),
        .osr_code  (cfg_osr_sel),
        .rst_m1    (rst_m1),
        .skip_m1   (skip_m1),
        .acc_m1    (acc_m1)
    );

    iadc_seq_fsm #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .mode      (cfg_mode),
        .start_req (oneshot_wr | trig_edge),
        .stop_seq  (stop_seq),
        .done_clr  (done_clr),
        .rst_m1    (rst_m1),
        .skip_m1   (skip_m1),
        .acc_m1    (acc_m1),
        .latch_cfg (latch_cfg),
        .mod_rst   (mod_rst),
        .skip_ph   (skip_ph),
        .acc_ph    (acc_ph),
        .conv_end  (conv_end),
        .busy      (busy),
        .chan_idx  (chan_idx),
        .done_sts  (done_sts)
    );

endmodule

// File: rtl/iadc_seq_chk.sv
module iadc_seq_chk #(
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en,
    input logic            done_clr,
    input logic            mod_rst,
    input logic            skip_ph,
    input logic            acc_ph,
    input logic            conv_end,
    input logic            busy,
    input logic [CH_W-1:0] chan_idx,
    input logic            done_sts
);

    p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mod_rst, skip_ph, acc_ph}));

    p_rst_then_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst && cfg_en |=> (mod_rst || skip_ph));

    p_skip_then_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        skip_ph && cfg_en |=> (skip_ph || acc_ph));

    p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ph && !conv_end && cfg_en |=> acc_ph);

    p_end_in_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end |-> acc_ph);

    p_entry_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mod_rst);

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !busy);

    p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_sts) |-> $past(conv_end));

    p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_clr && !conv_end |=> !done_sts);

    p_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end |=> (!busy || mod_rst));

    p_idle_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (chan_idx == '0));

endmodule

bind iadc_seq_top iadc_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .done_clr (done_clr),
    .mod_rst  (mod_rst),
    .skip_ph  (skip_ph),
    .acc_ph   (acc_ph),
    .conv_end (conv_end),
    .busy     (busy),
    .chan_idx (chan_idx),
    .done_sts (done_sts)
);

// File: tb/iadc_seq_top_tb.sv
module iadc_seq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 7;
    // rst code, skip code, osr code, expected reset, skip, accum lengths
    localparam int VEC [NVEC][6] = '{
        '{0, 0, 0,  50,  384,  32},
        '{1, 1, 1,  75,  576,  64},
        '{2, 2, 2, 100,  896,  96},
        '{3, 3, 3, 150, 1024, 128},
        '{1, 4, 0,  75, 2048,  32},
        '{0, 5, 1,  50, 4096,  64},
        '{0, 6, 0,  50, 4096,  32}
    };
    localparam int MIN_CONV = 50 + 384 + 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] cfg_rst_sel = 2'd0;
    logic [2:0] cfg_skip_sel = 3'd0;
    logic [1:0] cfg_osr_sel = 2'd0;
    logic [1:0] cfg_trig_src = 2'd0;
    logic       oneshot_wr = 1'b0;
    logic       stop_seq = 1'b0;
    logic       done_clr = 1'b0;
    logic [2:0] gpio_in = 3'd0;
    logic       mod_rst, skip_ph, acc_ph, conv_end, busy, done_sts;
    logic [1:0] chan_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    int nr, ns, na, nconv, nbusy, nend;
    bit order_bad;
    int chan_hist [8];

    iadc_seq_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_mode     (cfg_mode),
        .cfg_rst_sel  (cfg_rst_sel),
        .cfg_skip_sel (cfg_skip_sel),
        .cfg_osr_sel  (cfg_osr_sel),
        .cfg_trig_src (cfg_trig_src),
        .oneshot_wr   (oneshot_wr),
        .stop_seq     (stop_seq),
        .done_clr     (done_clr),
        .gpio_in      (gpio_in),
        .mod_rst      (mod_rst),
        .skip_ph      (skip_ph),
        .acc_ph       (acc_ph),
        .conv_end     (conv_end),
        .busy         (busy),
        .chan_idx     (chan_idx),
        .done_sts     (done_sts)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_oneshot();
        @(negedge clk);
        oneshot_wr = 1'b1;
        @(negedge clk);
        oneshot_wr = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    // Samples at falling edges until busy drops. The first sample is the one
    // taken at the current falling edge.
    // stop_at: after this many conversion starts, raise stop_seq (0 = never).
    task automatic observe(input int stop_at, input int poke_at);
        int last_p = 0;
        int p;
        int guard = 0;
        bit prev_rst = 1'b0;
        nr = 0; ns = 0; na = 0; nconv = 0; nbusy = 0; nend = 0;
        order_bad = 1'b0;
        for (int i = 0; i < 8; i++) chan_hist[i] = -1;
        while (busy && guard < 60000) begin
            guard++;
            nbusy++;
            if (mod_rst) nr++;
            if (skip_ph) ns++;
            if (acc_ph)  na++;
            if (conv_end) nend++;
            if (mod_rst && !prev_rst) begin
                if (nconv < 8) chan_hist[nconv] = int'(chan_idx);
                nconv++;
                if (stop_at != 0 && nconv == stop_at) stop_seq = 1'b1;
            end
            prev_rst = mod_rst;
            p = mod_rst ? 1 : skip_ph ? 2 : acc_ph ? 3 : 0;
            if ((mod_rst + skip_ph + acc_ph) != 1) order_bad = 1'b1;
            if (p < last_p && !(p == 1 && last_p == 3)) order_bad = 1'b1;
            last_p = p;
            if (poke_at != 0 && nbusy == poke_at) begin
                oneshot_wr = 1'b1;
                gpio_in    = 3'b111;
            end else begin
                oneshot_wr = 1'b0;
            end
            @(negedge clk);
        end
        oneshot_wr = 1'b0;
    endtask

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        check("R6 reset done_sts", int'(done_sts), 0);
        check("R4 reset busy", int'(busy), 0);
        check("R4 reset strobes", int'({mod_rst, skip_ph, acc_ph}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: start ignored while disabled
        pulse_oneshot();
        repeat (3) @(negedge clk);
        check("R5 disabled start ignored", int'(busy), 0);
        cfg_en = 1'b1;

        // Table walk: one-shot single-channel conversions with each code
        for (int v = 0; v < NVEC; v++) begin
            cfg_mode     = 2'd0;
            cfg_rst_sel  = 2'(VEC[v][0]);
            cfg_skip_sel = 3'(VEC[v][1]);
            cfg_osr_sel  = 2'(VEC[v][2]);
            @(negedge clk);
            oneshot_wr = 1'b1;
            @(negedge clk);
            check("R6 start latency", int'(mod_rst), 1);
            observe(0, 0);
            check("R1 reset length", nr, VEC[v][3]);
            check("R2 skip length", ns, VEC[v][4]);
            check("R3 accum length", na, VEC[v][5]);
            check("R4 order and total", int'(order_bad) * 100000 + nbusy,
                  VEC[v][3] + VEC[v][4] + VEC[v][5]);
            check("R4 single end pulse", nend, 1);
            check("R11 single chan", chan_hist[0], 0);
            check("R6 done after one-shot", int'(done_sts), 1);
            pulse_clear();
            check("R6 done cleared", int'(done_sts), 0);
        end

        cfg_rst_sel = 2'd0; cfg_skip_sel = 3'd0; cfg_osr_sel = 2'd0;

        // R8: start requests during a conversion are ignored
        cfg_trig_src = 2'd1;
        @(negedge clk);
        oneshot_wr = 1'b1;
        @(negedge clk);
        observe(0, 100);
        gpio_in = 3'd0;
        repeat (5) @(negedge clk);
        check("R8 busy start ignored total", nbusy, MIN_CONV);
        check("R8 no restart afterwards", int'(busy), 0);
        pulse_clear();

        // R7: pin start latency through the synchronizer
        cfg_trig_src = 2'd2;
        repeat (4) @(negedge clk);
        gpio_in[1] = 1'b1;
        @(negedge clk);
        check("R7 pin latency edge1", int'(busy), 0);
        @(negedge clk);
        check("R7 pin latency edge2", int'(busy), 0);
        @(negedge clk);
        check("R7 pin latency edge3", int'(mod_rst), 1);
        observe(0, 0);
        check("R7 pin conversion total", nbusy, MIN_CONV);
        gpio_in = 3'd0;
        pulse_clear();

        // R7: unselected pin and disabled source ignored
        cfg_trig_src = 2'd3;
        repeat (4) @(negedge clk);
        gpio_in[0] = 1'b1;
        gpio_in[1] = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 unselected pins ignored", int'(busy), 0);
        gpio_in = 3'd0;
        cfg_trig_src = 2'd0;
        repeat (4) @(negedge clk);
        gpio_in = 3'b111;
        repeat (6) @(negedge clk);
        check("R7 source zero ignored", int'(busy), 0);
        gpio_in = 3'd0;
        repeat (4) @(negedge clk);

        // R5: enable drop aborts
        pulse_oneshot();
        repeat (20) @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        check("R5 abort on enable low", int'(busy), 0);
        check("R5 abort sets no done", int'(done_sts), 0);
        cfg_en = 1'b1;

        // R9: sequential multichannel wraps, R10: stop after fifth conversion
        cfg_mode = 2'd3;
        stop_seq = 1'b0;
        @(negedge clk);
        oneshot_wr = 1'b1;
        @(negedge clk);
        observe(5, 0);
        check("R9 seq multi chan0", chan_hist[0], 0);
        check("R9 seq multi chan1", chan_hist[1], 1);
        check("R9 seq multi chan2", chan_hist[2], 2);
        check("R9 seq multi chan3", chan_hist[3], 3);
        check("R9 seq multi wrap", chan_hist[4], 0);
        check("R10 stop completes current", nbusy, 5 * MIN_CONV);
        check("R10 conversions run", nconv, 5);
        check("R6 sequential sets no done", int'(done_sts), 0);
        check("R4 seq order", int'(order_bad), 0);

        // R9: one-shot multichannel sweeps once
        stop_seq = 1'b0;
        cfg_mode = 2'd1;
        @(negedge clk);
        oneshot_wr = 1'b1;
        @(negedge clk);
        observe(0, 0);
        check("R9 oneshot multi count", nconv, 4);
        check("R9 oneshot multi last chan", chan_hist[3], 3);
        check("R9 oneshot multi total", nbusy, 4 * MIN_CONV);
        check("R6 oneshot multi done", int'(done_sts), 1);
        check("R9 idle chan", int'(chan_idx), 0);
        pulse_clear();

        // R11 / R10: sequential single with stop already high runs once
        cfg_mode = 2'd2;
        stop_seq = 1'b1;
        @(negedge clk);
        oneshot_wr = 1'b1;
        @(negedge clk);
        observe(0, 0);
        check("R10 stop high runs one", nconv, 1);
        check("R11 seq single chan", chan_hist[0], 0);
        check("R6 seq single no done", int'(done_sts), 0);

        // R11: sequential single keeps chan 0 over several conversions
        stop_seq = 1'b0;
        @(negedge clk);
        oneshot_wr = 1'b1;
        @(negedge clk);
        observe(3, 0);
        check("R11 seq single chan second", chan_hist[1], 0);
        check("R11 seq single chan third", chan_hist[2], 0);
        check("R10 seq single count", nconv, 3);
        stop_seq = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule